// File: doc/BRIEF.md
# HDLC Transmit Frame Encapsulator

This block turns byte-wide packet data into a serial HDLC bit stream, one bit per clock. The upstream source hands over bytes on a ready/valid handshake, marking the final byte of each packet and, when needed, marking a byte as an abort request. A frame begins with the first byte accepted after the previous frame ended. Between frames the line carries continuous flag octets. Each frame can be preceded by up to three programmable header bytes, for example an address, a control and a protocol byte. It can be closed by an inverted 16-bit or 32-bit frame check sequence. Zero-bit stuffing keeps flag patterns out of the frame body.

Configuration is static and is changed only while reset is held. A per-byte bit-order option selects whether the most significant or the least significant bit of each byte goes out first. A bypass mode switches off framing, header insertion, FCS, stuffing, abort and fill, so bytes are serialized as they are. In bypass mode only the bit-order option still applies. The source is stalled, through in_ready, while stuffed bits, header bytes, FCS bits, flags or abort bits are on the line.

Top module: `hdlc_tx_encap`

## Requirements
- R1: After reset in HDLC mode (cfg_hdlc_en=1), tx_valid is 1 on every cycle and the line carries back-to-back flags 0x7E until a frame starts.
- R2: Every byte is serialized over 8 consecutive line bits. This covers payload and header bytes, and bypass bytes. With cfg_bit_rev=0 bit 7 goes out first and bit 0 last; with cfg_bit_rev=1 bit 0 goes out first and bit 7 last.
- R3: When a frame starts with cfg_hdr_cnt=N (N from 1 to 3), N header bytes are sent before the first payload byte, header byte k being cfg_hdr[8k+7:8k], k=0 first. No input byte is accepted while they are sent.
- R4: With cfg_fcs_en=1, after the last payload byte the block sends the FCS: 16 bits when cfg_fcs32=0, 32 bits when cfg_fcs32=1. The register starts at all ones at frame start. Each header and payload bit d, in line order, updates it as fb=d^msb, reg=(reg<<1)^(fb ? poly : 0). Poly is 0x1021 (x^16+x^12+x^5+1) or 0x04C11DB7 (x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1). The register is then sent inverted, highest-order bit first, with no bit reversal.
- R5: After any five consecutive ones within header, payload or FCS bits, a single 0 is inserted on the next cycle. This happens even if the frame content ends there. Flag and abort bits are never stuffed and do not count toward a run.
- R6: Each frame that ends normally or by abort is followed by at least one complete flag. Flags continue as fill while no byte is offered at a flag boundary.
- R7: A byte accepted with in_abort=1 in HDLC mode is discarded. The block then sends eight ones, after any pending stuffed zero, and then returns to flags.
- R8: If in_valid is low when the next payload byte of an unfinished frame is needed, the frame is aborted with eight ones, as in R7.
- R9: A byte is transferred only on a cycle with in_valid=1 and in_ready=1. in_ready is 0 on every cycle that carries a stuffed zero.
- R10: In bypass mode (cfg_hdlc_en=0) bytes are serialized back to back with no flags, header, FCS or stuffing. in_last and in_abort have no effect. tx_valid is 0 on cycles with no byte to send.
- R11: With cfg_fcs_en=0, a flag follows directly after the last payload bit, or after its stuffed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hdlc_en | input | 1 | 1 = HDLC framing, 0 = bypass |
| cfg_bit_rev | input | 1 | 1 = bit 0 of each byte sent first |
| cfg_fcs_en | input | 1 | Append FCS |
| cfg_fcs32 | input | 1 | 1 = 32-bit FCS, 0 = 16-bit FCS |
| cfg_hdr_cnt | input | HDR_CNT_W (2) | Number of header bytes, 0 to HDR_MAX |
| cfg_hdr | input | 8*HDR_MAX (24) | Header bytes, byte k in bits 8k+7:8k |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Block takes the byte this cycle |
| in_data | input | 8 | Source byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_abort | input | 1 | Abort the frame in progress |
| tx_valid | output | 1 | tx_bit carries a line bit |
| tx_bit | output | 1 | Serial line bit |

## Verification
The bench builds the block with its default HDR_MAX of 3. This makes a three-byte header reachable, and with it the case where every header slot is used before payload fetch resumes. Four configurations run one after another, each entered under reset:
- 16-bit FCS with a two-byte header whose first byte is all ones;
- 32-bit FCS with LSB-first order and no header;
- FCS off with a full header;
- bypass.

Together they bring into reach stuffing inside headers and across the FCS boundary, back-to-back frames, abort on the first byte, underrun and the ignored markers of bypass mode.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FLAG,
        S_HDR,
        S_DATA,
        S_FCS,
        S_ABORT,
        S_BYP
    } tx_state_e;

    localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
    localparam logic [7:0]  ABORT_OCTET = 8'hFF;
    localparam int          STUFF_RUN   = 5;
    localparam int          FCS_MAX_W   = 32;
    localparam logic [31:0] POLY_16     = 32'h0000_1021;
    localparam logic [31:0] POLY_32     = 32'h04C1_1DB7;
    localparam logic [31:0] MASK_16     = 32'h0000_FFFF;

    // One decision taken at a byte boundary: what the shifter loads next
    typedef struct packed {
        logic       ld;
        tx_state_e  st;
        logic [7:0] bits;
        logic       last;
        logic       preset;
        logic       hdr_step;
    } load_t;

    // Arrange a byte so that index 0 is the first bit on the line
    function automatic logic [7:0] wire_order(input logic [7:0] b, input logic lsb_first);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = lsb_first ? b[i] : b[7-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_zero_stuff.sv
module hdlc_zero_stuff
    import hdlc_tx_pkg::*;
#(
    parameter int RUN = STUFF_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic emit,
    input  logic emit_bit,
    input  logic stuffable,
    output logic stuff_now
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones;

    assign stuff_now = (ones == CW'(RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ones <= '0;
        end else if (stuff_now) begin
            ones <= '0;
        end else if (emit) begin
            ones <= (stuffable && emit_bit) ? ones + 1'b1 : '0;
        end
    end

    // R5: the run counter never passes the stuffing threshold
    a_r5_run_limit: assert property (@(posedge clk) disable iff (rst)
        ones <= CW'(RUN));

    // R5: exactly one zero is inserted per run of ones
    a_r5_single_stuff: assert property (@(posedge clk) disable iff (rst)
        stuff_now |=> !stuff_now);

endmodule

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
    import hdlc_tx_pkg::*;
#(
    parameter int W = FCS_MAX_W
) (
    input  logic clk,
    input  logic rst,
    input  logic fcs32,
    input  logic preset,
    input  logic feed,
    input  logic feed_bit,
    input  logic drain,
    output logic fcs_bit
);
    logic [W-1:0] c;
    logic [W-1:0] mask;
    logic [W-1:0] poly;
    logic         msb;
    logic         fb;

    assign mask    = fcs32 ? W'(32'hFFFF_FFFF) : W'(MASK_16);
    assign poly    = fcs32 ? W'(POLY_32) : W'(POLY_16);
    assign msb     = fcs32 ? c[W-1] : c[15];
    assign fb      = feed_bit ^ msb;
    assign fcs_bit = ~msb;

    always_ff @(posedge clk) begin
        if (rst || preset) begin
            c <= '1;
        end else if (feed) begin
            c <= ((c << 1) ^ (fb ? poly : '0)) & mask;
        end else if (drain) begin
            c <= (c << 1) & mask;
        end
    end

    // R4: the register starts every frame at all ones
    a_r4_preset_ones: assert property (@(posedge clk) disable iff (rst)
        preset |=> ((c & mask) == mask));

    // R4: computation and draining never overlap
    a_r4_feed_drain_excl: assert property (@(posedge clk) disable iff (rst)
        !(feed && drain));

endmodule

// File: rtl/hdlc_tx_encap.sv
module hdlc_tx_encap
    import hdlc_tx_pkg::*;
#(
    parameter int HDR_MAX   = 3,
    parameter int HDR_CNT_W = $clog2(HDR_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_hdlc_en,
    input  logic                   cfg_bit_rev,
    input  logic                   cfg_fcs_en,
    input  logic                   cfg_fcs32,
    input  logic [HDR_CNT_W-1:0]   cfg_hdr_cnt,
    input  logic [8*HDR_MAX-1:0]   cfg_hdr,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [7:0]             in_data,
    input  logic                   in_last,
    input  logic                   in_abort,
    output logic                   tx_valid,
    output logic                   tx_bit
);
    localparam int FCNT_W = $clog2(FCS_MAX_W);

    tx_state_e             st;
    logic [7:0]            sh;
    logic [2:0]            idx;
    logic [HDR_CNT_W-1:0]  hdr_i;
    logic                  last_q;
    logic [FCNT_W-1:0]     fcs_cnt;

    logic [7:0]            hdr_b [HDR_MAX];
    logic [7:0]            hsel;
    logic                  stuff_now;
    logic                  fcs_bit;
    logic                  adv;
    logic                  cur_bit;
    logic                  stuffable;
    logic                  byte_end;
    logic [FCNT_W-1:0]     fcs_last;
    load_t                 fetched;
    load_t                 flag_ld;
    load_t                 nx;

    for (genvar k = 0; k < HDR_MAX; k++) begin : g_hdr
        assign hdr_b[k] = cfg_hdr[8*k +: 8];
    end

    assign fcs_last  = cfg_fcs32 ? FCNT_W'(31) : FCNT_W'(15);
    assign adv       = (st != S_IDLE) && !stuff_now;
    assign cur_bit   = (st == S_FCS) ? fcs_bit : sh[idx];
    assign stuffable = (st == S_HDR) || (st == S_DATA) || (st == S_FCS);
    assign byte_end  = adv && ((st == S_FCS) ? (fcs_cnt == fcs_last) : (idx == 3'd7));
    assign tx_valid  = (st != S_IDLE);
    assign tx_bit    = (st != S_IDLE) && !stuff_now && cur_bit;

    always_comb begin
        hsel = '0;
        for (int k = 0; k < HDR_MAX; k++) begin
            if (HDR_CNT_W'(k) == hdr_i) hsel = hdr_b[k];
        end

        // what an input fetch produces
        fetched      = '0;
        fetched.ld   = 1'b1;
        fetched.bits = wire_order(in_data, cfg_bit_rev);
        if (!cfg_hdlc_en) begin
            fetched.st = in_valid ? S_BYP : S_IDLE;
        end else if (in_valid && !in_abort) begin
            fetched.st   = S_DATA;
            fetched.last = in_last;
        end else begin
            fetched.st   = S_ABORT;
            fetched.bits = ABORT_OCTET;
        end

        flag_ld      = '0;
        flag_ld.ld   = 1'b1;
        flag_ld.st   = S_FLAG;
        flag_ld.bits = FLAG_OCTET;

        nx       = '0;
        in_ready = 1'b0;
        unique case (st)
            S_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) nx = fetched;
            end
            S_BYP: begin
                if (byte_end) begin
                    in_ready = 1'b1;
                    nx       = fetched;
                end
            end
            S_FLAG: begin
                if (byte_end) begin
                    if (!in_valid) begin
                        nx = flag_ld;
                    end else if (cfg_hdr_cnt != '0) begin
                        nx.ld       = 1'b1;
                        nx.st       = S_HDR;
                        nx.bits     = wire_order(hdr_b[0], cfg_bit_rev);
                        nx.hdr_step = 1'b1;
                        nx.preset   = 1'b1;
                    end else begin
                        in_ready  = 1'b1;
                        nx        = fetched;
                        nx.preset = 1'b1;
                    end
                end
            end
            S_HDR: begin
                if (byte_end) begin
                    if (hdr_i != cfg_hdr_cnt) begin
                        nx.ld       = 1'b1;
                        nx.st       = S_HDR;
                        nx.bits     = wire_order(hsel, cfg_bit_rev);
                        nx.hdr_step = 1'b1;
                    end else begin
                        in_ready = 1'b1;
                        nx       = fetched;
                    end
                end
            end
            S_DATA: begin
                if (byte_end) begin
                    if (last_q) begin
                        if (cfg_fcs_en) begin
                            nx.ld = 1'b1;
                            nx.st = S_FCS;
                        end else begin
                            nx = flag_ld;
                        end
                    end else begin
                        in_ready = 1'b1;
                        nx       = fetched;
                    end
                end
            end
            S_FCS, S_ABORT: begin
                if (byte_end) nx = flag_ld;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= cfg_hdlc_en ? S_FLAG : S_IDLE;
            sh      <= FLAG_OCTET;
            idx     <= '0;
            last_q  <= 1'b0;
            fcs_cnt <= '0;
        end else if (nx.ld) begin
            st      <= nx.st;
            sh      <= nx.bits;
            idx     <= '0;
            last_q  <= nx.last;
            fcs_cnt <= '0;
        end else if (adv) begin
            idx <= idx + 3'd1;
            if (st == S_FCS) fcs_cnt <= fcs_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_i <= '0;
        end else if (nx.hdr_step) begin
            hdr_i <= (st == S_FLAG) ? HDR_CNT_W'(1) : hdr_i + 1'b1;
        end
    end

    hdlc_zero_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst       (rst),
        .emit      (adv),
        .emit_bit  (cur_bit),
        .stuffable (stuffable),
        .stuff_now (stuff_now)
    );

    hdlc_fcs_gen #(.W(FCS_MAX_W)) u_fcs (
        .clk      (clk),
        .rst      (rst),
        .fcs32    (cfg_fcs32),
        .preset   (nx.preset),
        .feed     (adv && (st == S_HDR || st == S_DATA)),
        .feed_bit (sh[idx]),
        .drain    (adv && (st == S_FCS)),
        .fcs_bit  (fcs_bit)
    );

    // R1: in HDLC mode the line is never idle
    a_r1_line_busy: assert property (@(posedge clk) disable iff (rst)
        cfg_hdlc_en |-> tx_valid);

    // R9: the source is stalled while a stuffed zero is on the line
    a_r9_stall_on_stuff: assert property (@(posedge clk) disable iff (rst)
        stuff_now |-> !in_ready);

    // R7: abort bits are all ones apart from a pending stuffed zero
    a_r7_abort_ones: assert property (@(posedge clk) disable iff (rst)
        (st == S_ABORT && !stuff_now) |-> tx_bit);

    // R6: the FCS is always closed by a flag
    a_r6_flag_after_fcs: assert property (@(posedge clk) disable iff (rst)
        (st == S_FCS && byte_end) |=> (st == S_FLAG && sh == FLAG_OCTET));

    // R10: bypass mode never enters a framing state
    a_r10_bypass_states: assert property (@(posedge clk) disable iff (rst)
        !cfg_hdlc_en |-> (st == S_IDLE || st == S_BYP));

endmodule

// File: tb/tb_hdlc_tx_encap.sv
module tb_hdlc_tx_encap;

    localparam int HM = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_hdlc_en = 1'b1, cfg_bit_rev = 1'b0, cfg_fcs_en = 1'b1, cfg_fcs32 = 1'b0;
    logic [1:0] cfg_hdr_cnt = '0;
    logic [8*HM-1:0] cfg_hdr = '0;
    logic in_valid = 1'b0, in_last = 1'b0, in_abort = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, tx_valid, tx_bit;

    always #5 clk = ~clk;

    hdlc_tx_encap #(.HDR_MAX(HM)) dut (
        .clk(clk), .rst(rst), .cfg_hdlc_en(cfg_hdlc_en), .cfg_bit_rev(cfg_bit_rev),
        .cfg_fcs_en(cfg_fcs_en), .cfg_fcs32(cfg_fcs32), .cfg_hdr_cnt(cfg_hdr_cnt),
        .cfg_hdr(cfg_hdr), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_abort(in_abort), .tx_valid(tx_valid), .tx_bit(tx_bit)
    );

    typedef struct {
        bit    b;
        bit    stf;
        string tag;
    } ebit_t;

    ebit_t      eq[$];
    logic [7:0] fd [8][8];
    int         fl [8];
    int         fab [8];
    int         fgap [8];
    int         fidle [8];
    int         nf = 0;
    int         mf = 0;
    bit         just_framed = 0;
    bit         seen = 0;
    bit         pv_valid = 0;
    logic [7:0] pv_data = '0;
    int         nchk = 0;
    int         nerr = 0;
    bit         done = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push(input bit b, input bit stf, input string tag);
        ebit_t e;
        e.b = b; e.stf = stf; e.tag = tag;
        eq.push_back(e);
    endtask

    task automatic push_flag(input string tag);
        for (int i = 0; i < 8; i++) push((i != 0 && i != 7), 1'b0, tag);
    endtask

    // line-order bits of one byte per R2
    task automatic add_byte(input logic [7:0] b, input string tag, inout bit cb[$], inout string ct[$]);
        for (int i = 0; i < 8; i++) begin
            cb.push_back(cfg_bit_rev ? b[i] : b[7-i]);
            ct.push_back(tag);
        end
    endtask

    task automatic expand_frame(input int f);
        bit          cb[$];
        string       ct[$];
        int          nb;
        bit          normal;
        logic [31:0] c, mask, poly;
        bit          fb;
        int          w, run;
        normal = (fab[f] < 0) && (fgap[f] < 0);
        nb = (fab[f] >= 0) ? fab[f] : (fgap[f] >= 0) ? fgap[f] + 1 : fl[f];
        for (int k = 0; k < int'(cfg_hdr_cnt); k++) add_byte(cfg_hdr[8*k +: 8], "R3", cb, ct);
        for (int i = 0; i < nb; i++)
            add_byte(fd[f][i], (normal && !cfg_fcs_en && i == nb - 1) ? "R11" : "R2", cb, ct);
        if (normal && cfg_fcs_en) begin
            w    = cfg_fcs32 ? 32 : 16;
            mask = cfg_fcs32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            poly = cfg_fcs32 ? 32'h04C1_1DB7 : 32'h0000_1021;
            c    = mask;
            foreach (cb[i]) begin
                fb = cb[i] ^ c[w-1];
                c  = ((c << 1) ^ (fb ? poly : 32'h0)) & mask;
            end
            for (int j = w - 1; j >= 0; j--) begin
                cb.push_back(~c[j]);
                ct.push_back("R4");
            end
        end
        run = 0;
        foreach (cb[i]) begin
            push(cb[i], 1'b0, ct[i]);
            run = cb[i] ? run + 1 : 0;
            if (run == 5) begin
                push(1'b0, 1'b1, "R5");
                run = 0;
            end
        end
        if (!normal)
            for (int i = 0; i < 8; i++) push(1'b1, 1'b0, (fab[f] >= 0) ? "R7" : "R8");
    endtask

    task automatic refill();
        if (cfg_hdlc_en) begin
            if (just_framed) begin
                push_flag("R6");
                just_framed = 0;
            end else if (pv_valid && mf < nf) begin
                expand_frame(mf);
                mf++;
                just_framed = 1;
                seen = 1;
            end else begin
                push_flag(seen ? "R6" : "R1");
            end
        end else if (pv_valid) begin
            for (int i = 0; i < 8; i++) push(cfg_bit_rev ? pv_data[i] : pv_data[7-i], 1'b0, "R10");
        end
    endtask

    // reference model compared on every clock, away from the active edge
    always @(negedge clk) begin
        ebit_t e;
        if (rst) begin
            eq.delete();
            just_framed = 0;
            mf = 0;
            seen = 0;
        end else if (!done) begin
            if (eq.size() == 0) refill();
            if (eq.size() == 0) begin
                chk(tx_valid == 1'b0, "R10", "tx_valid while idle", int'(tx_valid), 0);
            end else begin
                e = eq.pop_front();
                chk(tx_valid == 1'b1 && tx_bit == e.b, e.tag, "line bit",
                    int'({tx_valid, tx_bit}), int'({1'b1, e.b}));
                if (e.stf) chk(in_ready == 1'b0, "R9", "in_ready on stuffed bit", int'(in_ready), 0);
            end
        end
        pv_valid = in_valid;
        pv_data  = in_data;
    end

    task automatic add_frame(input logic [63:0] b, input int len, input int ab, input int gp, input int idle);
        for (int i = 0; i < 8; i++) fd[nf][i] = b[8*i +: 8];
        fl[nf] = len; fab[nf] = ab; fgap[nf] = gp; fidle[nf] = idle;
        nf++;
    endtask

    task automatic send_frame(input int f);
        int nsend;
        nsend = (fab[f] >= 0) ? fab[f] + 1 : (fgap[f] >= 0) ? fgap[f] + 1 : fl[f];
        repeat (fidle[f]) @(posedge clk);
        #1;
        for (int i = 0; i < nsend; i++) begin
            in_valid = 1'b1;
            in_data  = fd[f][i];
            in_last  = (fab[f] < 0 && fgap[f] < 0 && i == fl[f] - 1);
            in_abort = (i == fab[f]);
            do @(negedge clk); while (!in_ready);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_abort = 1'b0;
    endtask

    task automatic run_phase(input bit hen, input bit rev, input bit fen, input bit f32,
                             input logic [1:0] hc, input logic [23:0] hdr);
        rst = 1'b1;
        cfg_hdlc_en = hen; cfg_bit_rev = rev; cfg_fcs_en = fen; cfg_fcs32 = f32;
        cfg_hdr_cnt = hc; cfg_hdr = hdr;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int f = 0; f < nf; f++) send_frame(f);
        repeat (80) @(posedge clk);
        chk(mf == nf || !hen, "R6", "frames consumed by model", mf, nf);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // phase A: FCS-16, MSB first, two header bytes (0xFF then 0x03)
        nf = 0;
        add_frame(64'h00_3E_12_FF_7E, 5, -1, -1, 5);
        add_frame(64'hFF_FF, 2, -1, -1, 0);
        add_frame(64'h0F_5A_A5, 3, 2, -1, 3);
        add_frame(64'h44_33_22_11, 4, -1, 1, 2);
        add_frame(64'hC3, 1, -1, -1, 10);
        run_phase(1, 0, 1, 0, 2'd2, 24'h00_03_FF);

        // phase B: FCS-32, LSB first, no header, abort on first byte
        nf = 0;
        add_frame(64'h1F_F8_80_01, 4, -1, -1, 4);
        add_frame(64'h7E, 1, -1, -1, 0);
        add_frame(64'h55, 1, 0, -1, 6);
        add_frame(64'hFE_FF_FF_FF, 4, -1, -1, 1);
        run_phase(1, 1, 1, 1, 2'd0, 24'h0);

        // phase C: FCS off, full three-byte header
        nf = 0;
        add_frame(64'hFC_3F, 2, -1, -1, 2);
        add_frame(64'h99, 1, -1, -1, 0);
        add_frame(64'hF8, 1, -1, -1, 7);
        run_phase(1, 0, 0, 0, 2'd3, 24'hEF_CD_AB);

        // phase D: bypass, LSB first, markers set but ignored
        nf = 0;
        add_frame(64'h42_81, 2, 1, -1, 3);
        add_frame(64'h7E_00_FF, 3, -1, -1, 0);
        add_frame(64'h5C, 1, -1, -1, 5);
        add_frame(64'h3C_E7, 2, -1, -1, 0);
        run_phase(0, 1, 1, 0, 2'd2, 24'h00_03_FF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule